// File: doc/BRIEF.md
# Radio Power Mode Controller

This block sequences a radio transceiver through five operating modes: off, standby, sleep, transmit and receive. Three baseband control pins drive it: a power request, an oscillator enable and a packet strobe. Two configuration bits, transmit-enable and receive-enable, also drive it. From the current mode it derives the following outputs:

- a power enable for each subsystem (reference oscillator, synthesizer, transmit path, receive path, power amplifier)
- a reset for the configuration registers
- the direction of the bidirectional baseband data pin
- the gate for the reference-clock output
- a low-rate clock that toggles only while the device sleeps

The mode register and the low-rate divider are the only sequential state apart from two flags. The flags remember which path was active when sleep was entered, so that path's supply stays up during sleep. All other outputs are decoded combinationally from the mode and the current pin levels.

Top module: `power_mode_ctrl`

## Requirements
- R1: While and after synchronous reset the controller is in OFF (mode code 0). `cfg_rst_o`=1. All power enables, `ref_clk_en_o`, `data_oe_o` and `lf_clk_o` are 0.
- R2: A low `pwr_req_i` at a clock edge puts the controller in OFF from any mode. In OFF, a high `pwr_req_i` moves it to IDLE (code 1) at the next edge. In OFF, `cfg_rst_o` is 1 and every power enable is 0.
- R3: In IDLE only `osc_pwr_o` is set among the power enables, and `cfg_rst_o` is 0.
- R4: From IDLE, a low `osc_en_i` enters SLEEP (code 2). From SLEEP, a high `osc_en_i` returns to IDLE. In SLEEP `osc_pwr_o`, `synth_pwr_o` and `cfg_rst_o` are 0.
- R5: From IDLE with `osc_en_i` high, `tx_en_i` alone enters TX (code 3) and `rx_en_i` alone enters RX (code 4). With both set, the controller stays in IDLE. A low `osc_en_i` takes priority and enters SLEEP.
- R6: In TX `osc_pwr_o`, `synth_pwr_o` and `tx_pwr_o` are 1 and `data_oe_o` is 0. `pa_on_o` equals `pkt_strobe_i` in the same cycle. The controller leaves TX to SLEEP when `osc_en_i` is low, otherwise to IDLE when `tx_en_i` is low or `rx_en_i` is high.
- R7: In RX `osc_pwr_o`, `synth_pwr_o`, `rx_pwr_o` and `data_oe_o` are 1. `sync_det_o` equals `pkt_strobe_i` in the same cycle. Exits from RX mirror R6 with the roles of the two enable bits swapped.
- R8: SLEEP entered from TX keeps `tx_pwr_o` at 1, and SLEEP entered from RX keeps `rx_pwr_o` at 1, for the whole stay. SLEEP entered from IDLE keeps both at 0.
- R9: `lf_clk_o` is 0 outside SLEEP. In SLEEP it is a 50% duty square wave: it is 0 for the first HALF cycles after entry and then toggles every HALF cycles. HALF is `LF_HALF_FAST` when `lf_sel_i`=0 and `LF_HALF_SLOW` when `lf_sel_i`=1.
- R10: `ref_clk_en_o` equals `osc_en_i` in every mode except OFF, where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req_i | input | 1 | Baseband power request |
| osc_en_i | input | 1 | Baseband oscillator enable |
| pkt_strobe_i | input | 1 | Packet strobe: power-amplifier start in TX, sync flag in RX |
| tx_en_i | input | 1 | Transmit-enable configuration bit |
| rx_en_i | input | 1 | Receive-enable configuration bit |
| lf_sel_i | input | 1 | Low-rate clock select: 0 fast, 1 slow |
| mode_o | output | 3 | Current mode code |
| cfg_rst_o | output | 1 | Configuration register reset |
| osc_pwr_o | output | 1 | Reference oscillator power enable |
| synth_pwr_o | output | 1 | Synthesizer power enable |
| tx_pwr_o | output | 1 | Transmit path power enable |
| rx_pwr_o | output | 1 | Receive path power enable |
| pa_on_o | output | 1 | Power amplifier stage enable |
| sync_det_o | output | 1 | Sync-word indication in RX |
| data_oe_o | output | 1 | 1 when the block drives the data pin |
| ref_clk_en_o | output | 1 | Reference clock output gate |
| lf_clk_o | output | 1 | Low-rate sleep clock |

## Verification
Mode changes land at the clock edge after the inputs that cause them, and the decoded outputs follow the new mode in the same cycle. The strobe-driven outputs and the clock gate follow their pins with no delay. The bench therefore drives each input one time unit after a rising edge. It checks the mode and all decoded outputs one time unit after the next edge, and rechecks the strobe-driven outputs one time unit after changing the strobe alone. The low-rate clock is due HALF edges after sleep entry for each level. It is compared edge by edge against k/HALF mod 2, where k counts edges since entry.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_OFF   = 3'd0,
        PM_IDLE  = 3'd1,
        PM_SLEEP = 3'd2,
        PM_TX    = 3'd3,
        PM_RX    = 3'd4
    } pmode_t;

    typedef struct packed {
        logic cfg_rst;
        logic osc;
        logic synth;
        logic txp;
        logic rxp;
        logic pa;
        logic sync;
        logic oe;
        logic refclk;
    } pm_ctl_t;

    function automatic pmode_t pm_next(pmode_t cur, logic pwr, logic osc,
                                       logic tx, logic rx);
        pmode_t n;
        n = cur;
        if (!pwr) begin
            n = PM_OFF;
        end else begin
            case (cur)
                PM_OFF:   n = PM_IDLE;
                PM_IDLE: begin
                    if (!osc)            n = PM_SLEEP;
                    else if (tx && !rx)  n = PM_TX;
                    else if (rx && !tx)  n = PM_RX;
                    else                 n = PM_IDLE;
                end
                PM_SLEEP: n = osc ? PM_IDLE : PM_SLEEP;
                PM_TX: begin
                    if (!osc)            n = PM_SLEEP;
                    else if (!tx || rx)  n = PM_IDLE;
                    else                 n = PM_TX;
                end
                PM_RX: begin
                    if (!osc)            n = PM_SLEEP;
                    else if (!rx || tx)  n = PM_IDLE;
                    else                 n = PM_RX;
                end
                default:  n = PM_OFF;
            endcase
        end
        return n;
    endfunction

    function automatic int unsigned pm_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pwr_req,
    input  logic   osc_en,
    input  logic   tx_en,
    input  logic   rx_en,
    output pmode_t state,
    output logic   held_tx,
    output logic   held_rx
);

    pmode_t nxt;

    always_comb begin
        nxt = pm_next(state, pwr_req, osc_en, tx_en, rx_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PM_OFF;
            held_tx <= 1'b0;
            held_rx <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == PM_SLEEP && state != PM_SLEEP) begin
                held_tx <= (state == PM_TX);
                held_rx <= (state == PM_RX);
            end else if (nxt != PM_SLEEP) begin
                held_tx <= 1'b0;
                held_rx <= 1'b0;
            end
        end
    end

    a_r2_drop_to_off: assert property (@(posedge clk) disable iff (rst)
        !pwr_req |=> state == PM_OFF);

    a_r2_leave_off: assert property (@(posedge clk) disable iff (rst)
        (state == PM_OFF && pwr_req) |=> state == PM_IDLE);

    a_r4_idle_to_sleep: assert property (@(posedge clk) disable iff (rst)
        (state == PM_IDLE && pwr_req && !osc_en) |=> state == PM_SLEEP);

    a_r5_both_stay_idle: assert property (@(posedge clk) disable iff (rst)
        (state == PM_IDLE && pwr_req && osc_en && tx_en && rx_en) |=> state == PM_IDLE);

    a_r8_keep_tx_path: assert property (@(posedge clk) disable iff (rst)
        (state == PM_TX && pwr_req && !osc_en) |=> (held_tx && !held_rx));

endmodule

// File: rtl/pmc_lfclk.sv
module pmc_lfclk
    import pmc_pkg::*;
#(
    parameter int unsigned LF_HALF_FAST = 203,
    parameter int unsigned LF_HALF_SLOW = 2031
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic sel,
    output logic lf_clk
);

    localparam int unsigned HMAX = pm_max(LF_HALF_FAST, LF_HALF_SLOW);
    localparam int unsigned CW   = (HMAX > 1) ? $clog2(HMAX) : 1;

    localparam logic [CW-1:0] LIM_FAST = CW'(LF_HALF_FAST - 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(LF_HALF_SLOW - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        lim = sel ? LIM_SLOW : LIM_FAST;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt    <= '0;
            lf_clk <= 1'b0;
        end else if (cnt >= lim) begin
            cnt    <= '0;
            lf_clk <= ~lf_clk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r9_quiet_when_awake: assert property (@(posedge clk) disable iff (rst)
        !run |=> !lf_clk);

    a_r9_toggle_at_limit: assert property (@(posedge clk) disable iff (rst)
        (run && cnt < lim) |=> $stable(lf_clk));

endmodule

// File: rtl/pmc_decode.sv
module pmc_decode
    import pmc_pkg::*;
(
    input  pmode_t  state,
    input  logic    held_tx,
    input  logic    held_rx,
    input  logic    pkt_strobe,
    input  logic    osc_en,
    output pm_ctl_t ctl
);

    always_comb begin
        ctl         = '0;
        ctl.cfg_rst = (state == PM_OFF);
        ctl.refclk  = (state != PM_OFF) && osc_en;
        unique case (state)
            PM_IDLE: ctl.osc = 1'b1;
            PM_SLEEP: begin
                ctl.txp = held_tx;
                ctl.rxp = held_rx;
            end
            PM_TX: begin
                ctl.osc   = 1'b1;
                ctl.synth = 1'b1;
                ctl.txp   = 1'b1;
                ctl.pa    = pkt_strobe;
            end
            PM_RX: begin
                ctl.osc   = 1'b1;
                ctl.synth = 1'b1;
                ctl.rxp   = 1'b1;
                ctl.sync  = pkt_strobe;
                ctl.oe    = 1'b1;
            end
            default: ctl.cfg_rst = 1'b1;
        endcase
    end

    always_comb begin
        a_r6_r7_paths_exclusive: assert (!(ctl.txp && ctl.rxp));
    end

endmodule

// File: rtl/power_mode_ctrl.sv
module power_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned LF_HALF_FAST = 203,
    parameter int unsigned LF_HALF_SLOW = 2031
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_req_i,
    input  logic       osc_en_i,
    input  logic       pkt_strobe_i,
    input  logic       tx_en_i,
    input  logic       rx_en_i,
    input  logic       lf_sel_i,
    output logic [2:0] mode_o,
    output logic       cfg_rst_o,
    output logic       osc_pwr_o,
    output logic       synth_pwr_o,
    output logic       tx_pwr_o,
    output logic       rx_pwr_o,
    output logic       pa_on_o,
    output logic       sync_det_o,
    output logic       data_oe_o,
    output logic       ref_clk_en_o,
    output logic       lf_clk_o
);

    pmode_t  state;
    logic    held_tx;
    logic    held_rx;
    pm_ctl_t ctl;

    pmc_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pwr_req (pwr_req_i),
        .osc_en  (osc_en_i),
        .tx_en   (tx_en_i),
        .rx_en   (rx_en_i),
        .state   (state),
        .held_tx (held_tx),
        .held_rx (held_rx)
    );

    pmc_decode u_dec (
        .state      (state),
        .held_tx    (held_tx),
        .held_rx    (held_rx),
        .pkt_strobe (pkt_strobe_i),
        .osc_en     (osc_en_i),
        .ctl        (ctl)
    );

    pmc_lfclk #(
        .LF_HALF_FAST (LF_HALF_FAST),
        .LF_HALF_SLOW (LF_HALF_SLOW)
    ) u_lf (
        .clk    (clk),
        .rst    (rst),
        .run    (state == PM_SLEEP),
        .sel    (lf_sel_i),
        .lf_clk (lf_clk_o)
    );

    assign mode_o       = state;
    assign cfg_rst_o    = ctl.cfg_rst;
    assign osc_pwr_o    = ctl.osc;
    assign synth_pwr_o  = ctl.synth;
    assign tx_pwr_o     = ctl.txp;
    assign rx_pwr_o     = ctl.rxp;
    assign pa_on_o      = ctl.pa;
    assign sync_det_o   = ctl.sync;
    assign data_oe_o    = ctl.oe;
    assign ref_clk_en_o = ctl.refclk;

    a_r7_drive_only_rx: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> (state == PM_RX && !tx_pwr_o));

    a_r1_off_holds_reset: assert property (@(posedge clk) disable iff (rst)
        (state == PM_OFF) |-> (cfg_rst_o && !osc_pwr_o && !ref_clk_en_o));

endmodule

// File: tb/sim_power_mode_ctrl.sv
module sim_power_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int HF = 3;
    localparam int HS = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr = 1'b0, osc = 1'b0, pkt = 1'b0, txe = 1'b0, rxe = 1'b0, sel = 1'b0;
    logic [2:0] mode;
    logic cfg_rst, osc_pwr, synth_pwr, tx_pwr, rx_pwr, pa_on, sync_det, data_oe, ref_en, lf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int em;
    bit ehtx, ehrx;

    always #(CLK_PERIOD/2) clk = ~clk;

    power_mode_ctrl #(.LF_HALF_FAST(HF), .LF_HALF_SLOW(HS)) u0 (
        .clk(clk), .rst(rst), .pwr_req_i(pwr), .osc_en_i(osc), .pkt_strobe_i(pkt),
        .tx_en_i(txe), .rx_en_i(rxe), .lf_sel_i(sel), .mode_o(mode),
        .cfg_rst_o(cfg_rst), .osc_pwr_o(osc_pwr), .synth_pwr_o(synth_pwr),
        .tx_pwr_o(tx_pwr), .rx_pwr_o(rx_pwr), .pa_on_o(pa_on), .sync_det_o(sync_det),
        .data_oe_o(data_oe), .ref_clk_en_o(ref_en), .lf_clk_o(lf)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_of(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    // expected {mode, cfg_rst, osc, synth, tx, rx, pa, sync, oe, refclk}
    function automatic logic [11:0] exp_vec();
        logic [11:0] v;
        v = {em[2:0], 9'b0};
        v[8] = (em == 0);
        v[7] = (em == 1 || em == 3 || em == 4);
        v[6] = (em == 3 || em == 4);
        v[5] = (em == 3) || (em == 2 && ehtx);
        v[4] = (em == 4) || (em == 2 && ehrx);
        v[3] = (em == 3) && pkt;
        v[2] = (em == 4) && pkt;
        v[1] = (em == 4);
        v[0] = (em != 0) && osc;
        return v;
    endfunction

    function automatic logic [11:0] act_vec();
        return {mode, cfg_rst, osc_pwr, synth_pwr, tx_pwr, rx_pwr, pa_on, sync_det, data_oe, ref_en};
    endfunction

    task automatic model_step();
        int n;
        n = em;
        if (!pwr) n = 0;
        else if (em == 0) n = 1;
        else if (em == 2) n = osc ? 1 : 2;
        else if (!osc) n = 2;
        else if (em == 1) n = (txe && !rxe) ? 3 : ((rxe && !txe) ? 4 : 1);
        else if (em == 3) n = (!txe || rxe) ? 1 : 3;
        else n = (!rxe || txe) ? 1 : 4;
        if (n == 2 && em != 2) begin
            ehtx = (em == 3);
            ehrx = (em == 4);
        end else if (n != 2) begin
            ehtx = 1'b0;
            ehrx = 1'b0;
        end
        em = n;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; pwr = 0; osc = 0; pkt = 0; txe = 0; rxe = 0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        em = 0; ehtx = 0; ehrx = 0;
    endtask

    task automatic reach(int s);
        do_reset();
        if (s >= 1) begin pwr = 1; osc = 1; tick(); end
        if (s == 2) begin osc = 0; tick(); end
        if (s == 3) begin txe = 1; tick(); end
        if (s == 4) begin rxe = 1; tick(); end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", {20'b0, act_vec()}, {20'b0, 3'd0, 9'b100000000});
        chk("R1 lf", {31'b0, lf}, 32'd0);

        // near-exhaustive sweep: every start mode, every input combination
        for (int s = 0; s < 5; s++) begin
            for (int c = 0; c < 16; c++) begin
                reach(s);
                chk(tag_of(em), {20'b0, act_vec()}, {20'b0, exp_vec()});
                pwr = c[3]; osc = c[2]; txe = c[1]; rxe = c[0];
                tick();
                chk(tag_of(em), {20'b0, act_vec()}, {20'b0, exp_vec()});
                pkt = 1'b1; #1;
                chk(em == 3 ? "R6 strobe" : (em == 4 ? "R7 strobe" : "R10 strobe"),
                    {20'b0, act_vec()}, {20'b0, exp_vec()});
                pkt = 1'b0;
            end
        end

        // R5 both enables hold IDLE over several cycles
        reach(1); txe = 1; rxe = 1;
        tick(); tick();
        chk("R5 both set", {29'b0, mode}, 32'd1);

        // R8 sleep from TX keeps tx path, from RX keeps rx path
        reach(3); osc = 0; tick(); tick(); tick();
        chk("R8 from tx", {30'b0, tx_pwr, rx_pwr}, 32'b10);
        reach(4); osc = 0; tick(); tick();
        chk("R8 from rx", {30'b0, tx_pwr, rx_pwr}, 32'b01);
        reach(2); tick();
        chk("R8 from idle", {30'b0, tx_pwr, rx_pwr}, 32'b00);

        // R10 clock gate in IDLE follows osc, OFF forces 0
        reach(1); txe = 0; rxe = 0;
        chk("R10 idle on", {31'b0, ref_en}, 32'd1);
        pwr = 0; tick();
        osc = 1;
        #1 chk("R10 off", {31'b0, ref_en}, 32'd0);

        // R9 low-rate clock, both selections
        for (int sv = 0; sv < 2; sv++) begin
            int h;
            h = (sv == 1) ? HS : HF;
            reach(1);
            sel = sv[0];
            osc = 0; tick();           // enters SLEEP, k = 0
            for (int k = 0; k < 4 * h; k++) begin
                chk("R9 wave", {31'b0, lf}, ((k / h) % 2));
                tick();
            end
            osc = 1; tick(); tick();
            chk("R9 off after wake", {31'b0, lf}, 32'd0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule